// File: doc/BRIEF.md
# Programmable Clock Generator Channel

This block is one channel of a clock generation unit. A 5-bit source code picks one of several incoming clocks, and the channel divides that clock to produce an internal generator clock. Division is either linear, by an 8-bit divisor, or by a power of two whose exponent comes from the same divisor. For odd linear divisors, an optional balancing stage stretches the high phase by half an input period, which gives a 50/50 duty cycle.

The channel also drives a pad. The pad carries the generator clock when output is enabled. Otherwise it sits at a programmable idle level. When the channel's own pad is selected as the clock input, the pad driver is released. In standby, a pair of bits decides whether the channel keeps running, and a peripheral request can keep the internal clock alive while the pad is not in use.

The configuration is held in a register that is loaded by a single strobe on the control clock. A power-on reset puts every channel into its reset state. A user reset does the same, but it is blocked while the lock input is high. Divisor and mode changes take effect at the next output period boundary. Clearing the enable, or any other condition that stops the channel, forces the generator clock low at once.

Top module: `clkGenChannel`

## Requirements
- R1: With `cfgPow2`=0 the generator clock is the selected clock divided by `cfgDiv`. Divisor values 0 and 1 pass the selected clock through unchanged.
- R2: With `cfgPow2`=0, `cfgBalance`=0 and an odd divisor N≥3, each output period is high for (N-1)/2 input periods and low for (N+1)/2 input periods.
- R3: With `cfgPow2`=0, `cfgBalance`=1 and an odd divisor, high and low each last N/2 input periods. Even divisors give the same waveform whatever the value of `cfgBalance`.
- R4: With `cfgPow2`=1 the division is 2^min(`cfgDiv`+1,16), with a 50/50 duty cycle. `cfgBalance` has no effect in this mode.
- R5: Source code 0 selects `extClk[0]`. Code 1 selects `padIn`. A code c in 2..NUM_SRC-1 selects `extClk[c-1]`. Codes NUM_SRC..31 give no clock, so the generator clock stays 0. Code 2 also gives no clock when GEN_ID is 1.
- R6: While `cfgEn`=0 the generator clock is 0. With a source other than code 1, if `cfgEn`=0 or `cfgOe`=0, `padOut` equals `cfgOffVal`.
- R7: With a source other than code 1, and with `cfgEn`=1 and `cfgOe`=1 outside standby, `padOe`=1 and `padOut` follows the generator clock. With source code 1, `padOe`=0 regardless of `cfgOe` and `cfgOffVal`.
- R8: When `standby`=1:
  - If `cfgOe`=1 and `cfgRunStby`=1, the channel runs and drives the pad.
  - If `cfgOe`=1 and `cfgRunStby`=0, the generator clock stops and `padOut` holds `cfgOffVal`.
  - If `cfgOe`=0, the generator clock runs only while `periphReq`=1.
- R9: Power-on reset loads the enable bit 1, source code 5 and all other fields 0 when GEN_ID is 0, and all fields 0 otherwise. A user reset loads the same values unless `lockIn`=1, in which case the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the configuration register |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| userRstN | input | 1 | Synchronous user reset, active low, blocked by lockIn |
| lockIn | input | 1 | Keeps the configuration through a user reset |
| cfgLoad | input | 1 | Loads the cfg* fields into the configuration register |
| cfgEn | input | 1 | Generator enable |
| cfgSrc | input | 5 | Source code |
| cfgDiv | input | 8 | Divisor, or exponent base in power-of-two mode |
| cfgPow2 | input | 1 | 1 selects power-of-two division |
| cfgBalance | input | 1 | Duty balancing for odd linear divisors |
| cfgOe | input | 1 | Pad output enable |
| cfgOffVal | input | 1 | Pad idle level |
| cfgRunStby | input | 1 | Keep running on the pad during standby |
| standby | input | 1 | Standby flag |
| periphReq | input | 1 | A peripheral needs the generator clock |
| extClk | input | NUM_SRC-1 | Clock inputs for every source code except the pad |
| padIn | input | 1 | Pad level, used as a source |
| genClk | output | 1 | Internal generator clock |
| padOut | output | 1 | Pad output level |
| padOe | output | 1 | Pad driver enable |

## Verification
The bench measures the high and low durations of the generator clock for even, odd balanced, odd unbalanced, pass-through and power-of-two divisors, including the saturated 65536 case. These measurements expose several kinds of error:
- Halving a counter bound the wrong way swaps the odd phase lengths.
- A missing falling-edge stage leaves balanced periods lopsided.
- An exponent that does not saturate wraps to a short period.

The bench also selects reserved codes and the code that is invalid only for channel 1, where any leakage of a clock is an error. It walks the standby and pad-source combinations to catch a pad that is driven when it should be released or that idles at the wrong level. Finally, it issues a user reset with and without the lock, which shows whether the configuration is lost or wrongly kept.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef struct packed {
    logic       en;
    logic       runStby;
    logic       pow2;
    logic       oe;
    logic       offVal;
    logic       balance;
    logic [4:0] src;
    logic [7:0] div;
  } cfgT;

  // strobes from control to datapath
  typedef struct packed {
    logic       run;
    logic       srcOk;
    logic       pow2;
    logic       balance;
    logic [7:0] div;
  } ctrlT;

endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int GEN_ID  = 0,
  parameter int NUM_SRC = 11,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             userRstN,
  input  logic             lockIn,
  input  logic             cfgLoad,
  input  cfgT              cfgNew,
  input  logic             standby,
  input  logic             periphReq,
  output cfgT              cfgCur,
  output ctrlT             ctrl,
  output logic [IDX_W-1:0] srcIdx,
  output logic             padShow,
  output logic             padOe
);

  localparam logic [4:0] SRC_LAST = 5'(NUM_SRC - 1);
  localparam logic [4:0] SRC_PAD  = 5'd1;
  localparam logic [4:0] SRC_GEN1 = 5'd2;
  localparam cfgT RST_CFG = (GEN_ID == 0) ? cfgT'({6'b100000, 5'd5, 8'd0}) : cfgT'('0);

  cfgT  cfgQ;
  logic srcOk;
  logic stbyKeep;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                cfgQ <= RST_CFG;
    else if (!userRstN && !lockIn) cfgQ <= RST_CFG;
    else if (cfgLoad)            cfgQ <= cfgNew;
  end

  always_comb begin
    srcOk    = (cfgQ.src <= SRC_LAST) && !((GEN_ID == 1) && (cfgQ.src == SRC_GEN1));
    stbyKeep = (cfgQ.oe && cfgQ.runStby) || (!cfgQ.oe && periphReq);
    ctrl.run     = cfgQ.en && srcOk && (!standby || stbyKeep);
    ctrl.srcOk   = srcOk;
    ctrl.pow2    = cfgQ.pow2;
    ctrl.balance = cfgQ.balance;
    ctrl.div     = cfgQ.div;
    padOe        = (cfgQ.src != SRC_PAD);
    padShow      = cfgQ.en && cfgQ.oe && padOe && (!standby || cfgQ.runStby);
  end

  assign srcIdx = cfgQ.src[IDX_W-1:0];
  assign cfgCur = cfgQ;

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
  import clkgen_pkg::*;
#(
  parameter int EXP_MAX = 16
) (
  input  logic selClk,
  input  logic rstN,
  input  ctrlT ctrl,
  output logic genClk
);

  localparam int CNT_W = EXP_MAX;
  localparam int PER_W = EXP_MAX + 1;
  localparam int EXP_W = $clog2(EXP_MAX + 1);

  logic [CNT_W-1:0] cnt, curLast, curHalf;
  logic             curBypass, curBal;
  logic             qPos, qNeg;

  logic [EXP_W-1:0] expo;
  logic [PER_W-1:0] nextPeriod;
  logic [CNT_W-1:0] nextLast, nextHalf;
  logic             nextBypass, nextBal, wrap;

  always_comb begin
    expo = (ctrl.div >= 8'(EXP_MAX - 1)) ? EXP_W'(EXP_MAX) : EXP_W'(ctrl.div + 8'd1);
    if (ctrl.pow2)          nextPeriod = PER_W'(1) << expo;
    else if (ctrl.div < 8'd2) nextPeriod = PER_W'(1);
    else                    nextPeriod = PER_W'(ctrl.div);
    nextLast   = CNT_W'(nextPeriod - PER_W'(1));
    nextHalf   = CNT_W'(nextPeriod >> 1);
    nextBypass = !ctrl.pow2 && (ctrl.div < 8'd2);
    nextBal    = !ctrl.pow2 && ctrl.balance && ctrl.div[0];
    wrap       = (cnt == curLast);
  end

  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0; curLast <= '0; curHalf <= '0;
      curBypass <= 1'b0; curBal <= 1'b0; qPos <= 1'b0;
    end else if (!ctrl.run || wrap) begin
      cnt       <= '0;
      curLast   <= ctrl.run ? nextLast : '0;
      curHalf   <= nextHalf;
      curBypass <= nextBypass;
      curBal    <= nextBal;
      qPos      <= ctrl.run;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      qPos <= ((cnt + CNT_W'(1)) < curHalf);
    end
  end

  // half-period extension of the high phase
  always_ff @(negedge selClk or negedge rstN) begin
    if (!rstN) qNeg <= 1'b0;
    else       qNeg <= qPos;
  end

  assign genClk = ctrl.run & (curBypass ? selClk : (qPos | (curBal & qNeg)));

endmodule

// File: rtl/clkGenChannel.sv
module clkGenChannel
  import clkgen_pkg::*;
#(
  parameter int GEN_ID  = 0,
  parameter int NUM_SRC = 11,
  parameter int EXP_MAX = 16
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               userRstN,
  input  logic               lockIn,
  input  logic               cfgLoad,
  input  logic               cfgEn,
  input  logic [4:0]         cfgSrc,
  input  logic [7:0]         cfgDiv,
  input  logic               cfgPow2,
  input  logic               cfgBalance,
  input  logic               cfgOe,
  input  logic               cfgOffVal,
  input  logic               cfgRunStby,
  input  logic               standby,
  input  logic               periphReq,
  input  logic [NUM_SRC-2:0] extClk,
  input  logic               padIn,
  output logic               genClk,
  output logic               padOut,
  output logic               padOe
);

  localparam int IDX_W = $clog2(NUM_SRC);

  cfgT              cfgNew, cfgCur;
  ctrlT             ctrl;
  logic [IDX_W-1:0] srcIdx;
  logic             padShow, selClk;
  logic [NUM_SRC-1:0] srcVec;

  assign cfgNew = '{en: cfgEn, runStby: cfgRunStby, pow2: cfgPow2, oe: cfgOe,
                    offVal: cfgOffVal, balance: cfgBalance, src: cfgSrc, div: cfgDiv};

  for (genvar c = 0; c < NUM_SRC; c++) begin : g_src
    if (c == 0)      begin : g_first assign srcVec[c] = extClk[0];   end
    else if (c == 1) begin : g_pad   assign srcVec[c] = padIn;       end
    else             begin : g_ext   assign srcVec[c] = extClk[c-1]; end
  end

  assign selClk = ctrl.srcOk ? srcVec[srcIdx] : 1'b0;

  clkgen_ctrl #(.GEN_ID(GEN_ID), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .porRstN(porRstN), .userRstN(userRstN), .lockIn(lockIn),
    .cfgLoad(cfgLoad), .cfgNew(cfgNew), .standby(standby), .periphReq(periphReq),
    .cfgCur(cfgCur), .ctrl(ctrl), .srcIdx(srcIdx), .padShow(padShow), .padOe(padOe)
  );

  clkgen_div #(.EXP_MAX(EXP_MAX)) uDiv (
    .selClk(selClk), .rstN(porRstN), .ctrl(ctrl), .genClk(genClk)
  );

  assign padOut = padShow ? genClk : cfgCur.offVal;

endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input logic clk,
  input logic porRstN,
  input logic userRstN,
  input logic lockIn,
  input logic cfgLoad,
  input logic standby,
  input cfgT  cfgCur,
  input logic genClk,
  input logic padOut,
  input logic padOe
);

  localparam logic [4:0] SRC_LAST = 5'(NUM_SRC - 1);

  p_pad_released_r7: assert property (@(posedge clk) disable iff (!porRstN)
    (cfgCur.src == 5'd1) |-> !padOe);

  p_off_level_r6: assert property (@(posedge clk) disable iff (!porRstN)
    ((cfgCur.src != 5'd1) && (!cfgCur.en || !cfgCur.oe)) |-> (padOut == cfgCur.offVal));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!porRstN)
    !cfgCur.en |-> !genClk);

  p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (cfgCur.src > SRC_LAST) |-> !genClk);

  p_stby_idle_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (standby && cfgCur.oe && !cfgCur.runStby && cfgCur.src != 5'd1) |-> (padOut == cfgCur.offVal));

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!porRstN)
    (!userRstN && lockIn && !cfgLoad) |=> $stable(cfgCur));

endmodule

bind clkGenChannel clkgen_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk(clk), .porRstN(porRstN), .userRstN(userRstN), .lockIn(lockIn),
  .cfgLoad(cfgLoad), .standby(standby), .cfgCur(cfgCur), .genClk(genClk),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_clkGenChannel.sv
`timescale 1ns/1ps
module sim_clkGenChannel;

  logic clk = 0, porRstN = 0, userRstN = 1, lockIn = 0, cfgLoad = 0;
  logic cfgEn = 0, cfgPow2 = 0, cfgBalance = 0, cfgOe = 0, cfgOffVal = 0, cfgRunStby = 0;
  logic [4:0] cfgSrc = 0;
  logic [7:0] cfgDiv = 0;
  logic standby = 0, periphReq = 0;
  logic clkA = 0, clkB = 0, clkF = 0, clkP = 0;
  logic [9:0] extClk;
  logic genClk0, padOut0, padOe0, genClk1, padOut1, padOe1;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5    clk  = ~clk;
  always #10   clkA = ~clkA;
  always #20   clkB = ~clkB;
  always #1    clkF = ~clkF;
  always #15   clkP = ~clkP;
  // code0,2..4 -> clkA ; code5 -> clkB ; code6 -> clkF ; code7..10 -> clkA
  assign extClk = {{4{clkA}}, clkF, clkB, {3{clkA}}, clkA};

  clkGenChannel #(.GEN_ID(0)) u0 (
    .clk(clk), .porRstN(porRstN), .userRstN(userRstN), .lockIn(lockIn), .cfgLoad(cfgLoad),
    .cfgEn(cfgEn), .cfgSrc(cfgSrc), .cfgDiv(cfgDiv), .cfgPow2(cfgPow2), .cfgBalance(cfgBalance),
    .cfgOe(cfgOe), .cfgOffVal(cfgOffVal), .cfgRunStby(cfgRunStby), .standby(standby),
    .periphReq(periphReq), .extClk(extClk), .padIn(clkP),
    .genClk(genClk0), .padOut(padOut0), .padOe(padOe0));

  clkGenChannel #(.GEN_ID(1)) u1 (
    .clk(clk), .porRstN(porRstN), .userRstN(userRstN), .lockIn(lockIn), .cfgLoad(cfgLoad),
    .cfgEn(cfgEn), .cfgSrc(cfgSrc), .cfgDiv(cfgDiv), .cfgPow2(cfgPow2), .cfgBalance(cfgBalance),
    .cfgOe(cfgOe), .cfgOffVal(cfgOffVal), .cfgRunStby(cfgRunStby), .standby(standby),
    .periphReq(periphReq), .extClk(extClk), .padIn(clkP),
    .genClk(genClk1), .padOut(padOut1), .padOe(padOe1));

  typedef struct { realtime hi; realtime lo; string tag; } expT;
  expT expQ[$];

  task automatic report(input bit ok, input string tag, input string act, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic waitLevel(input logic lvl, output bit ok);
    realtime t0 = $realtime;
    ok = 1;
    while (genClk0 !== lvl) begin
      if ($realtime - t0 > 200000.0) begin ok = 0; return; end
      #0.25;
    end
  endtask

  // monitor: pops expected shapes and measures genClk of u0
  initial begin
    forever begin
      expT e;
      realtime t0, t1, t2;
      bit ok, okAll;
      wait (expQ.size() > 0);
      e = expQ[0];
      okAll = 1;
      repeat (2) begin
        waitLevel(1'b0, ok); okAll &= ok;
        waitLevel(1'b1, ok); okAll &= ok;
      end
      t0 = $realtime;
      waitLevel(1'b0, ok); okAll &= ok; t1 = $realtime;
      waitLevel(1'b1, ok); okAll &= ok; t2 = $realtime;
      if (!okAll)
        report(0, e.tag, "no clock", $sformatf("hi %0.1f lo %0.1f", e.hi, e.lo));
      else
        report(((t1 - t0 - e.hi) <= 1.0) && ((e.hi - (t1 - t0)) <= 1.0) &&
               ((t2 - t1 - e.lo) <= 1.0) && ((e.lo - (t2 - t1)) <= 1.0), e.tag,
               $sformatf("hi %0.2f lo %0.2f", t1 - t0, t2 - t1),
               $sformatf("hi %0.1f lo %0.1f", e.hi, e.lo));
      void'(expQ.pop_front());
    end
  end

  task automatic expectShape(input realtime hi, input realtime lo, input string tag);
    expT e;
    e.hi = hi; e.lo = lo; e.tag = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  task automatic setCfg(input logic en, input logic [4:0] src, input logic [7:0] div,
                        input logic p2, input logic bal, input logic oe, input logic oov,
                        input logic rs);
    @(negedge clk);
    cfgEn = en; cfgSrc = src; cfgDiv = div; cfgPow2 = p2; cfgBalance = bal;
    cfgOe = oe; cfgOffVal = oov; cfgRunStby = rs; cfgLoad = 1;
    @(negedge clk);
    cfgLoad = 0;
    #300;
  endtask

  task automatic checkLow(input int which, input int steps, input string tag);
    bit seen = 0;
    for (int i = 0; i < steps; i++) begin
      if ((which == 0 ? genClk0 : genClk1) !== 1'b0) seen = 1;
      #0.5;
    end
    report(!seen, tag, seen ? "clock seen" : "low", "low");
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    report(act === exp, tag, $sformatf("%b", act), $sformatf("%b", exp));
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #25 porRstN = 1;
    #100;
    // R9: power-on defaults
    expectShape(20, 20, "R9 channel0 reset runs src5 undivided");
    checkLow(1, 400, "R9 channel1 reset idle");
    checkBit(padOut1, 1'b0, "R9 channel1 pad off level");
    checkBit(padOe1, 1'b1, "R9 channel1 pad driven");

    // R1 linear and pass-through
    setCfg(1, 0, 4, 0, 0, 0, 0, 0); expectShape(40, 40, "R1 div4");
    setCfg(1, 0, 0, 0, 0, 0, 0, 0); expectShape(10, 10, "R1 div0 pass");
    setCfg(1, 0, 1, 0, 0, 0, 0, 0); expectShape(10, 10, "R1 div1 pass");
    setCfg(1, 0, 6, 0, 0, 0, 0, 0); expectShape(60, 60, "R1 div6");
    // R2 odd unbalanced
    setCfg(1, 0, 5, 0, 0, 0, 0, 0); expectShape(40, 60, "R2 div5");
    setCfg(1, 0, 3, 0, 0, 0, 0, 0); expectShape(20, 40, "R2 div3");
    // R3 balanced
    setCfg(1, 0, 5, 0, 1, 0, 0, 0); expectShape(50, 50, "R3 div5 balanced");
    setCfg(1, 0, 3, 0, 1, 0, 0, 0); expectShape(30, 30, "R3 div3 balanced");
    setCfg(1, 0, 4, 0, 1, 0, 0, 0); expectShape(40, 40, "R3 div4 balance no effect");
    // R4 power of two
    setCfg(1, 0, 2, 1, 0, 0, 0, 0); expectShape(80, 80, "R4 pow2 div2");
    setCfg(1, 0, 1, 1, 1, 0, 0, 0); expectShape(40, 40, "R4 pow2 balance ignored");
    setCfg(1, 6, 200, 1, 0, 0, 0, 0); expectShape(65536, 65536, "R4 exponent saturates");

    // R6 disabled
    setCfg(0, 0, 4, 0, 0, 1, 1, 0);
    checkLow(0, 400, "R6 disabled low");
    checkBit(padOut0, 1'b1, "R6 disabled pad off high");
    setCfg(1, 0, 4, 0, 0, 0, 1, 0);
    checkBit(padOut0, 1'b1, "R6 oe0 pad high");
    #37 checkBit(padOut0, 1'b1, "R6 oe0 pad high later");
    setCfg(1, 0, 4, 0, 0, 0, 0, 0);
    checkBit(padOut0, 1'b0, "R6 oe0 pad low");

    // R5 sources
    setCfg(1, 2, 0, 0, 0, 0, 0, 0);
    expectShape(10, 10, "R5 code2 channel0");
    checkLow(1, 400, "R5 code2 invalid channel1");
    setCfg(1, 11, 0, 0, 0, 0, 0, 0); checkLow(0, 400, "R5 code11 reserved");
    setCfg(1, 31, 4, 0, 0, 0, 0, 0); checkLow(0, 400, "R5 code31 reserved");
    setCfg(1, 1, 2, 0, 0, 1, 1, 0);
    expectShape(30, 30, "R5 pad source div2");
    checkBit(padOe0, 1'b0, "R7 pad source releases pad");

    // R7 pad follows generator clock
    setCfg(1, 0, 4, 0, 0, 1, 1, 0);
    checkBit(padOe0, 1'b1, "R7 pad driven");
    for (int k = 0; k < 6; k++) begin
      #13 checkBit(padOut0, genClk0, "R7 pad follows clock");
    end
    checkBit(padOut0, genClk0, "R7 pad follows clock final");

    // R8 standby
    standby = 1;
    #200 checkLow(0, 400, "R8 standby stopped");
    checkBit(padOut0, 1'b1, "R8 standby pad off level");
    setCfg(1, 0, 4, 0, 0, 1, 1, 1);
    expectShape(40, 40, "R8 run in standby");
    #7 checkBit(padOut0, genClk0, "R8 standby pad follows");
    periphReq = 1;
    setCfg(1, 0, 4, 0, 0, 0, 0, 0);
    expectShape(40, 40, "R8 peripheral request keeps clock");
    periphReq = 0;
    #200 checkLow(0, 400, "R8 no request stops clock");
    standby = 0;

    // R9 user reset with and without lock
    setCfg(1, 0, 4, 0, 0, 0, 0, 0);
    @(negedge clk); lockIn = 1; userRstN = 0;
    repeat (2) @(negedge clk);
    userRstN = 1; lockIn = 0;
    #300 expectShape(40, 40, "R9 locked user reset keeps config");
    @(negedge clk); userRstN = 0;
    repeat (2) @(negedge clk);
    userRstN = 1;
    #300 expectShape(20, 20, "R9 user reset restores default");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule